// File: doc/BRIEF.md
# Race-free wake-up pending register

This block captures edges on eight asynchronous input pins and holds each one as a pending bit until software acknowledges it. Every pin is brought into the clock domain through a two-flop synchronizer. It is then compared with its previous synchronized level. A per-pin select bit chooses whether a rising or a falling transition counts as an event. A detected event sets that pin's pending bit. The bit stays set until software clears it.

Software takes a snapshot of the pending bits with a read strobe. Later it writes back a mask of the bits it has handled, and only the bits written as 1 are cleared. An event that arrives between the read and the clear therefore stays pending. If an event lands on a bit in the same cycle that the bit is cleared, the event wins. An interrupt request is raised when any pending bit has its enable set. The pending bits stay readable with every enable off, so the block can also be polled.

Top module: `wake_pend_reg`

## Requirements
- R1: After reset, the read data, the interrupt request and all pending bits are 0.
- R2: With select bit i at 0, a 0-to-1 transition on pin i sets pending bit i. The bit is set on the third rising clock edge after the pin changes.
- R3: With select bit i at 1, a 1-to-0 transition on pin i sets pending bit i, with the same latency as R2.
- R4: A transition in the direction that is not selected leaves pending bit i unchanged.
- R5: Pending bits are set and held whatever the enable mask is.
- R6: A cycle with the clear write enable high clears exactly those pending bits whose clear-mask bit is 1. The other bits are unchanged.
- R7: When an event and a clear reach the same bit in the same cycle, the bit ends up set.
- R8: An event on one bit during a cycle that clears a different bit sets its own bit, and the cleared bit still goes to 0.
- R9: The interrupt request is a register. It is 1 in the cycle after a cycle in which some pending bit and its enable bit are both 1, and 0 otherwise.
- R10: A read strobe loads the pending bits into the read data on that clock edge. Without a strobe, the read data holds its value.
- R11: Events on several pins in the same cycle, or in successive cycles, all remain pending until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous event pins |
| edge_fall_i | input | 8 | Per-pin edge select: 0 = rising, 1 = falling |
| irq_en_i | input | 8 | Per-bit interrupt enable |
| rd_i | input | 1 | Read strobe; loads the snapshot |
| rd_data_o | output | 8 | Snapshot of the pending bits |
| clr_we_i | input | 1 | Clear write enable |
| clr_mask_i | input | 8 | Write-one-to-clear mask |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions take three things for granted:
- Each pin level is held for longer than the synchronizer depth plus one cycle, so every intended transition is actually detected.
- The select, enable, strobe and clear inputs are synchronous to the clock.
- A select bit changes only while its pin is quiet.

The bench meets these conditions in the following ways:
- It changes pins only at falling clock edges and then waits at least four cycles.
- It changes select bits only between events.
- It counts cycles from the pin change to place each clear exactly on the cycle in which the edge is detected, for the same bit and for a different bit.

// File: rtl/wake_pend_reg.sv
module wake_pend_reg #(
  parameter int N    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] edge_fall_i,
  input  logic [N-1:0] irq_en_i,
  input  logic         rd_i,
  output logic [N-1:0] rd_data_o,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic         irq_o
);

  logic [SYNC-1:0][N-1:0] sync_q;
  logic [N-1:0] level, prev_q, det, clr_eff, pend_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-2:0], pin_i};

  assign level = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;

  assign det     = (level & ~prev_q & ~edge_fall_i) | (~level & prev_q & edge_fall_i);
  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_eff) | det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(pend_q & irq_en_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    rd_data_o <= '0;
    else if (rd_i) rd_data_o <= pend_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2 R3 R7
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det[i] |=> pend_q[i]);
    // R6
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_eff[i] && !det[i] |=> !pend_q[i]);
    // R5 R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[i] && !clr_eff[i] |=> pend_q[i]);
    // R4
    no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[i] && !det[i] |=> !pend_q[i]);
  end

  // R9
  irq_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(pend_q & irq_en_i) |=> irq_o);
  // R9
  irq_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_q & irq_en_i)) |=> !irq_o);
  // R10
  rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rd_data_o == $past(pend_q));
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rd_data_o));

endmodule

// File: tb/test_wake_pend_reg.sv
module test_wake_pend_reg;
  localparam int PERIOD = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin = '0, sel = '0, en = '0, cmask = '0;
  logic rd = 0, cwe = 0;
  logic [N-1:0] rdata;
  logic irq;

  int total = 0, bad = 0;
  logic [N-1:0] exp_pend = '0;
  logic [N-1:0] exp_q[$];
  string tag_q[$];
  logic rd_fire = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  wake_pend_reg #(.N(N), .SYNC(2)) i_wake_pend_reg (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .edge_fall_i(sel), .irq_en_i(en),
    .rd_i(rd), .rd_data_o(rdata), .clr_we_i(cwe), .clr_mask_i(cmask), .irq_o(irq));

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_fire <= rd;

  // Monitor: compares each snapshot against the queued expectation.
  always @(negedge clk)
    if (rd_fire && exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());

  task automatic do_read(string req);
    rd = 1;
    exp_q.push_back(exp_pend);
    tag_q.push_back(req);
    @(posedge clk); @(negedge clk);
    rd = 0;
  endtask

  // Toggle pins; optionally clear in the cycle the edge is detected.
  task automatic toggle(logic [N-1:0] m, logic cl, logic [N-1:0] cm);
    logic [N-1:0] nw;
    nw = pin ^ m;
    pin = nw;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    if (cl) begin cwe = 1; cmask = cm; end
    @(posedge clk); @(negedge clk);
    cwe = 0; cmask = '0;
    exp_pend = (exp_pend & ~(cl ? cm : '0)) | (m & ((nw & ~sel) | (~nw & sel)));
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clear(logic [N-1:0] cm);
    cwe = 1; cmask = cm;
    @(posedge clk); @(negedge clk);
    cwe = 0; cmask = '0;
    exp_pend = exp_pend & ~cm;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_data", rdata, '0);
    check("R1 irq", {7'd0, irq}, '0);
    rst_n = 1;
    @(negedge clk);
    do_read("R1 pending");

    toggle(8'h01, 0, '0);
    do_read("R2 rising pin0");
    check("R5 irq while disabled", {7'd0, irq}, '0);

    toggle(8'h01, 0, '0);
    do_read("R4 falling ignored on rising select");

    sel = 8'h08;
    @(negedge clk);
    toggle(8'h08, 0, '0);
    do_read("R4 rising ignored on falling select");
    toggle(8'h08, 0, '0);
    do_read("R3 falling pin3");

    en = 8'h08;
    check("R9 irq not yet", {7'd0, irq}, '0);
    @(posedge clk); @(negedge clk);
    check("R9 irq raised", {7'd0, irq}, 8'h01);

    clear(8'h08);
    check("R9 irq one cycle late", {7'd0, irq}, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R9 irq dropped", {7'd0, irq}, '0);
    do_read("R6 clear only masked bit");

    toggle(8'h20, 1, 8'h20);
    do_read("R7 edge wins over same-bit clear");

    toggle(8'h04, 1, 8'h01);
    do_read("R8 edge during other-bit clear");

    toggle(8'hC2, 0, '0);
    do_read("R11 simultaneous events");

    en = 8'h80;
    @(posedge clk); @(negedge clk);
    check("R5 pending kept with mask", {7'd0, irq}, 8'h01);

    toggle(8'h10, 0, '0);
    check("R10 rd_data held without strobe", rdata, 8'hE6);
    do_read("R11 successive events");

    clear(8'hFF);
    do_read("R6 clear all");
    en = '0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule